// File: doc/BRIEF.md
# Audio Transmit Sample Packing FIFO

This block is the transmit side of an audio port. A host writes 32-bit data words. Each word carries either one sample or, in compact mode, two 16-bit samples. The block turns every sample into a 20-bit word aligned to the top of the field and padded with zeros below. It stores these words in a circular buffer whose depth is a parameter.

A downstream codec port pulls the stored words as stereo pairs, left word first, through a valid/ready handshake. Draining waits until the buffer is at least half full and then moves one pair per accepting cycle. Four status flags follow the fill state: empty, half-empty, full and underrun.

A control write sets the operating mode. It loads four fields: transmit enable, a two-bit mask of active audio slots, a sample-size code and the compact-mode request.

Top module: `audio_tx_pack_fifo`

## Requirements
- R1: Size code `ctl_size` selects the sample width: 0 = 16 bits, 1 = 18 bits, 2 = 20 bits, 3 = 12 bits. In non-compact mode one write stores one word. That word is `dat_wdata` shifted left by 4, 2, 0 or 8 bits for codes 0, 1, 2 or 3, keeping bits 19:0.
- R2: In compact mode one write stores two words, bits 15:0 first and then bits 31:16. Each half is shifted left by 8 for code 3 and by 4 for code 0, keeping bits 19:0.
- R3: A control write that requests compact mode with size code 1 or 2 sets non-compact mode. Later writes then store one word each.
- R4: A compact write is accepted only if `fill_level + 2 < DEPTH`. A non-compact write is accepted only if `fill_level < DEPTH`. A rejected write leaves the stored contents and `fill_level` unchanged. `fill_level` never exceeds DEPTH.
- R5: `cdc_valid` is high only when all of these hold: transmit is enabled, at least one bit of the slot mask is set (bit 0 = first audio slot, bit 1 = second), and `fill_level >= 2`. To start a burst, `fill_level >= DEPTH/2` is also needed. `cdc_left` and `cdc_right` are then the two oldest stored words.
- R6: After a cycle in which a pair was taken (`cdc_valid` and `cdc_ready` both high), the next cycle offers a pair whenever at least two words remain, even below half. A cycle with `cdc_valid` high and `cdc_ready` low ends the burst.
- R7: An accepted write clears empty and underrun. If the new level is at least DEPTH/2, it clears half-empty. If the new level equals DEPTH, it sets full.
- R8: A taken pair clears full. If the new level is at most DEPTH/2, it sets half-empty. If the new level is zero, it sets empty and underrun. When a write and a take happen in the same cycle, the take's updates win.
- R9: After reset the buffer holds nothing, empty and half-empty are set, full and underrun are clear, and no pair is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Load the control fields this cycle |
| ctl_en | input | 1 | Transmit enable |
| ctl_slots | input | 2 | Active audio slot mask |
| ctl_size | input | 2 | Sample-size code |
| ctl_compact | input | 1 | Compact-mode request |
| dat_wr | input | 1 | Data write strobe |
| dat_wdata | input | 32 | Data write word |
| cdc_valid | output | 1 | A stereo pair is offered |
| cdc_ready | input | 1 | Codec takes the offered pair |
| cdc_left | output | 20 | Left sample of the pair |
| cdc_right | output | 20 | Right sample of the pair |
| st_empty | output | 1 | Empty flag |
| st_half_empty | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |
| fill_level | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
The bench builds the block with DEPTH = 8, so half is 4. A few writes therefore reach the full flag, both overrun rules and the exactly-half level where the half-empty flag depends on history. Because the depth is small, the random phase keeps wrapping the pointers. It also often reaches a write and a take in the same cycle, and a burst that continues below half.

// File: rtl/audio_txp_pkg.sv
// Package: shared types and sample-formatting functions for the
// audio transmit packing FIFO. Assumes a fixed 20-bit stored word.
package audio_txp_pkg;

    localparam int SMP_W = 20;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ18 = 2'd1,
        SZ20 = 2'd2,
        SZ12 = 2'd3
    } size_code_e;

    // One sample per word, padded to the top of a 20-bit field.
    function automatic logic [SMP_W-1:0] pad_single(input logic [31:0] d,
                                                    input size_code_e s);
        case (s)
            SZ12:    return {d[11:0], 8'b0};
            SZ16:    return {d[15:0], 4'b0};
            SZ18:    return {d[17:0], 2'b0};
            default: return d[19:0];
        endcase
    endfunction

    // One 16-bit half of a compact word, padded to 20 bits.
    function automatic logic [SMP_W-1:0] pad_half(input logic [15:0] h,
                                                  input size_code_e s);
        if (s == SZ12) return {h[11:0], 8'b0};
        return {h, 4'b0};
    endfunction

    function automatic logic compact_allowed(input size_code_e s);
        return (s == SZ16) || (s == SZ12);
    endfunction

endpackage

// File: rtl/atp_packer.sv
// Module: atp_packer
// Turns one host data word into one or two 20-bit stored words.
// Assumes compact is only ever set with a 12- or 16-bit size code.
module atp_packer
    import audio_txp_pkg::*;
(
    input  logic [31:0]      wdata,
    input  size_code_e       size,
    input  logic             compact,
    output logic [SMP_W-1:0] word0,
    output logic [SMP_W-1:0] word1,
    output logic             two
);
    // Select single or dual formatting.
    always_comb begin
        two = compact;
        if (compact) begin
            word0 = pad_half(wdata[15:0], size);
            word1 = pad_half(wdata[31:16], size);
        end else begin
            word0 = pad_single(wdata, size);
            word1 = '0;
        end
    end
endmodule

// File: rtl/atp_ring.sv
// Module: atp_ring
// Circular word store with up to two writes and one pair read per cycle.
// Assumes DEPTH is a power of two and the caller never over/underfills it.
module atp_ring #(
    parameter int DEPTH = 8,
    parameter int W     = 20,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_one,
    input  logic          push_two,
    input  logic [W-1:0]  din0,
    input  logic [W-1:0]  din1,
    input  logic          pop_pair,
    output logic [W-1:0]  dout0,
    output logic [W-1:0]  dout1,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nxt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW-1:0] wp1, rp1;
    logic [LW-1:0] add_n, sub_n;

    // Neighbouring pointer positions and count deltas.
    always_comb begin
        wp1       = wp + 1'b1;
        rp1       = rp + 1'b1;
        add_n     = push_two ? LW'(2) : (push_one ? LW'(1) : '0);
        sub_n     = pop_pair ? LW'(2) : '0;
        level_nxt = level + add_n - sub_n;
    end

    // Storage writes, one or two consecutive slots.
    always_ff @(posedge clk) begin
        if (push_one || push_two) mem[wp] <= din0;
        if (push_two)             mem[wp1] <= din1;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + add_n[AW-1:0];
            if (pop_pair) rp <= rp + AW'(2);
            level <= level_nxt;
        end
    end

    assign dout0 = mem[rp];
    assign dout1 = mem[rp1];
endmodule

// File: rtl/atp_status.sv
// Module: atp_status
// Event-driven status flags; drain updates are applied after push updates.
// Assumes lvl_next is the level after this cycle's push and drain.
module atp_status #(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pushed,
    input  logic          popped,
    input  logic [LW-1:0] lvl_next,
    output logic          empty,
    output logic          half_empty,
    output logic          full,
    output logic          underrun
);
    localparam logic [LW-1:0] DEP_L  = LW'(DEPTH);
    localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

    // Flag register updates; later assignments take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty      <= 1'b1;
            half_empty <= 1'b1;
            full       <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            if (pushed) begin
                empty    <= 1'b0;
                underrun <= 1'b0;
                if (lvl_next >= HALF_L) half_empty <= 1'b0;
                if (lvl_next == DEP_L)  full <= 1'b1;
            end
            if (popped) begin
                full <= 1'b0;
                if (lvl_next <= HALF_L) half_empty <= 1'b1;
                if (lvl_next == '0) begin
                    empty    <= 1'b1;
                    underrun <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/audio_tx_pack_fifo.sv
// Module: audio_tx_pack_fifo
// Top: control latch, write acceptance, drain gating and pair handshake.
// Assumes DEPTH is a power of two in 8..2048.
module audio_tx_pack_fifo
    import audio_txp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    input  logic [1:0]    ctl_slots,
    input  logic [1:0]    ctl_size,
    input  logic          ctl_compact,
    input  logic          dat_wr,
    input  logic [31:0]   dat_wdata,
    output logic          cdc_valid,
    input  logic          cdc_ready,
    output logic [19:0]   cdc_left,
    output logic [19:0]   cdc_right,
    output logic          st_empty,
    output logic          st_half_empty,
    output logic          st_full,
    output logic          st_underrun,
    output logic [LW-1:0] fill_level
);
    localparam logic [LW:0]   DEP_X  = (LW + 1)'(DEPTH);
    localparam logic [LW-1:0] DEP_L  = LW'(DEPTH);
    localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

    logic          en_q, compact_q, burst_q;
    logic [1:0]    slots_q;
    size_code_e    size_q;
    logic [19:0]   w0, w1;
    logic          two, accept, pop;
    logic [LW-1:0] lvl_next;

    // Control register latch; compact is refused for wide samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            slots_q   <= 2'b00;
            size_q    <= SZ16;
            compact_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q      <= ctl_en;
            slots_q   <= ctl_slots;
            size_q    <= size_code_e'(ctl_size);
            compact_q <= ctl_compact && compact_allowed(size_code_e'(ctl_size));
        end
    end

    atp_packer u_pack (
        .wdata   (dat_wdata),
        .size    (size_q),
        .compact (compact_q),
        .word0   (w0),
        .word1   (w1),
        .two     (two)
    );

    // Room check against the level before this cycle's drain.
    always_comb begin
        if (compact_q) accept = dat_wr && (({1'b0, fill_level} + (LW + 1)'(2)) < DEP_X);
        else           accept = dat_wr && (fill_level < DEP_L);
    end

    // Pair offer: start at half full, continue while a burst runs.
    always_comb begin
        cdc_valid = en_q && (slots_q != 2'b00) && (fill_level >= LW'(2))
                    && (burst_q || (fill_level >= HALF_L));
        pop       = cdc_valid && cdc_ready;
    end

    // Burst tracker: remembers that the previous cycle moved a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) burst_q <= 1'b0;
        else        burst_q <= pop;
    end

    atp_ring #(.DEPTH(DEPTH), .W(SMP_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_one  (accept && !two),
        .push_two  (accept && two),
        .din0      (w0),
        .din1      (w1),
        .pop_pair  (pop),
        .dout0     (cdc_left),
        .dout1     (cdc_right),
        .level     (fill_level),
        .level_nxt (lvl_next)
    );

    atp_status #(.DEPTH(DEPTH)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .pushed     (accept),
        .popped     (pop),
        .lvl_next   (lvl_next),
        .empty      (st_empty),
        .half_empty (st_half_empty),
        .full       (st_full),
        .underrun   (st_underrun)
    );
endmodule

// File: rtl/atp_checker.sv
// Module: atp_checker
// Temporal checks on the packing FIFO, attached by bind.
// Assumes it sees the top's ports plus the latched enable.
module atp_checker #(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dat_wr,
    input logic          cdc_valid,
    input logic          cdc_ready,
    input logic          en_q,
    input logic          st_empty,
    input logic          st_full,
    input logic [LW-1:0] fill_level
);
    localparam logic [LW-1:0] DEP_L = LW'(DEPTH);
    localparam logic [LW-1:0] LOW_L = LW'(DEPTH - 2);

    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= DEP_L);

    a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && fill_level == DEP_L && !(cdc_valid && cdc_ready)) |=> fill_level == DEP_L);

    a_r5_valid_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_valid |-> (en_q && fill_level >= LW'(2)));

    a_r7_push_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && fill_level < LOW_L) |=> !st_empty);

    a_r7_full_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> fill_level == DEP_L);

    a_r8_take_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_valid && cdc_ready) |=> !st_full);

    a_r8_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_empty |-> fill_level == '0);
endmodule

bind audio_tx_pack_fifo atp_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dat_wr     (dat_wr),
    .cdc_valid  (cdc_valid),
    .cdc_ready  (cdc_ready),
    .en_q       (en_q),
    .st_empty   (st_empty),
    .st_full    (st_full),
    .fill_level (fill_level)
);

// File: tb/tb_audio_tx_pack_fifo.sv
// Bench: directed corner cases then seeded random traffic, all compared
// against a bench-side model built from the requirements.
module tb_audio_tx_pack_fifo;
    localparam int DEPTH = 8;
    localparam int HALF  = DEPTH / 2;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctl_wr, ctl_en, ctl_compact, dat_wr, cdc_ready;
    logic [1:0]    ctl_slots, ctl_size;
    logic [31:0]   dat_wdata;
    logic          cdc_valid, st_empty, st_half_empty, st_full, st_underrun;
    logic [19:0]   cdc_left, cdc_right;
    logic [LW-1:0] fill_level;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // model state
    logic [19:0] mq[$];
    bit       m_en, m_cp, m_burst;
    bit [1:0] m_sl, m_sz;
    bit       m_empty, m_he, m_full, m_ur;

    always #10 clk = ~clk;

    audio_tx_pack_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .ctl_slots(ctl_slots), .ctl_size(ctl_size), .ctl_compact(ctl_compact),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .cdc_valid(cdc_valid),
        .cdc_ready(cdc_ready), .cdc_left(cdc_left), .cdc_right(cdc_right),
        .st_empty(st_empty), .st_half_empty(st_half_empty), .st_full(st_full),
        .st_underrun(st_underrun), .fill_level(fill_level)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [19:0] b_pad1(input logic [31:0] d, input bit [1:0] sz);
        logic [31:0] t;
        case (sz)
            2'd3:    t = d << 8;
            2'd0:    t = d << 4;
            2'd1:    t = d << 2;
            default: t = d;
        endcase
        return t[19:0];
    endfunction

    function automatic logic [19:0] b_padh(input logic [15:0] h, input bit [1:0] sz);
        logic [31:0] t;
        t = {16'b0, h};
        t = (sz == 2'd3) ? (t << 8) : (t << 4);
        return t[19:0];
    endfunction

    // One clock of stimulus with full comparison against the model.
    task automatic step(input bit c_wr, input bit c_en, input bit [1:0] c_sl,
                        input bit [1:0] c_sz, input bit c_cp, input bit d_wr,
                        input logic [31:0] d_data, input bit rdy);
        bit ev, popped;
        int pre, nl;
        @(negedge clk);
        ctl_wr = c_wr; ctl_en = c_en; ctl_slots = c_sl; ctl_size = c_sz;
        ctl_compact = c_cp; dat_wr = d_wr; dat_wdata = d_data; cdc_ready = rdy;
        #1;
        pre = mq.size();
        ev  = m_en && (m_sl != 0) && (pre >= 2) && (m_burst || pre >= HALF);
        chk(cdc_valid == ev, "R5", 32'(cdc_valid), 32'(ev));
        if (ev && cdc_valid) begin
            chk(cdc_left == mq[0], "R1 R2 left", 32'(cdc_left), 32'(mq[0]));
            chk(cdc_right == mq[1], "R1 R2 right", 32'(cdc_right), 32'(mq[1]));
        end
        chk(int'(fill_level) == pre, "R4 level", 32'(fill_level), 32'(pre));
        chk({st_empty, st_half_empty, st_full, st_underrun} == {m_empty, m_he, m_full, m_ur},
            "R7 R8 flags", {28'b0, st_empty, st_half_empty, st_full, st_underrun},
            {28'b0, m_empty, m_he, m_full, m_ur});
        // model next state
        popped = ev && rdy;
        if (popped) begin void'(mq.pop_front()); void'(mq.pop_front()); end
        if (d_wr) begin
            if (m_cp) begin
                if (pre + 2 < DEPTH) begin
                    mq.push_back(b_padh(d_data[15:0], m_sz));
                    mq.push_back(b_padh(d_data[31:16], m_sz));
                    nl = mq.size();
                    m_empty = 0; m_ur = 0;
                    if (nl >= HALF) m_he = 0;
                    if (nl == DEPTH) m_full = 1;
                end
            end else if (pre < DEPTH) begin
                mq.push_back(b_pad1(d_data, m_sz));
                nl = mq.size();
                m_empty = 0; m_ur = 0;
                if (nl >= HALF) m_he = 0;
                if (nl == DEPTH) m_full = 1;
            end
        end
        nl = mq.size();
        if (popped) begin
            m_full = 0;
            if (nl <= HALF) m_he = 1;
            if (nl == 0) begin m_empty = 1; m_ur = 1; end
        end
        m_burst = popped;
        if (c_wr) begin
            m_en = c_en; m_sl = c_sl; m_sz = c_sz;
            m_cp = c_cp && (c_sz == 2'd0 || c_sz == 2'd3);
        end
        @(posedge clk); #1;
        ctl_wr = 0; dat_wr = 0; cdc_ready = 0;
    endtask

    task automatic cfg(input bit e, input bit [1:0] sl, input bit [1:0] sz, input bit cp);
        step(1, e, sl, sz, cp, 0, 32'h0, 0);
    endtask

    task automatic wr(input logic [31:0] d, input bit rdy);
        step(0, m_en, m_sl, m_sz, m_cp, 1, d, rdy);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        rst_n = 0; ctl_wr = 0; ctl_en = 0; ctl_slots = 0; ctl_size = 0;
        ctl_compact = 0; dat_wr = 0; dat_wdata = 0; cdc_ready = 0;
        m_en = 0; m_sl = 0; m_sz = 0; m_cp = 0; m_burst = 0;
        m_empty = 1; m_he = 1; m_full = 0; m_ur = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk(fill_level == 0 && !cdc_valid, "R9 level/valid", 32'(fill_level), 0);
        chk({st_empty, st_half_empty, st_full, st_underrun} == 4'b1100, "R9 flags",
            {st_empty, st_half_empty, st_full, st_underrun}, 32'hC);

        cfg(0, 2'b00, 2'd3, 0);          // 12-bit single
        wr(32'h00000ABC, 0);             // -> ABC00 (R1)
        cfg(0, 2'b00, 2'd2, 1);          // 20-bit, compact refused
        wr(32'h00012345, 0);             // one word -> 12345
        chk(fill_level == 2, "R3 single word", 32'(fill_level), 2);
        cfg(0, 2'b00, 2'd0, 1);          // 16-bit compact
        wr(32'h5555AAAA, 0);             // AAAA0 then 55550
        chk(fill_level == 4, "R2 two words", 32'(fill_level), 4);
        wr(32'h00010002, 0);             // 4+2<8 -> 6
        wr(32'h00030004, 0);             // 6+2 not <8 -> dropped
        chk(fill_level == 6, "R4 compact overrun", 32'(fill_level), 6);
        cfg(0, 2'b00, 2'd0, 0);
        wr(32'h00001234, 0);
        wr(32'h00005678, 0);
        chk(st_full == 1 && fill_level == 8, "R7 full set", 32'(fill_level), 8);
        wr(32'h00009999, 0);
        chk(fill_level == 8, "R4 single overrun", 32'(fill_level), 8);
        cfg(1, 2'b10, 2'd0, 0);          // enable, second slot only
        chk(cdc_valid && cdc_left == 20'hABC00 && cdc_right == 20'h12345, "R1 R5 first pair",
            32'(cdc_left), 32'hABC00);
        step(0, 1, 2'b10, 2'd0, 0, 0, 0, 1);
        step(0, 1, 2'b10, 2'd0, 0, 0, 0, 1);
        step(0, 1, 2'b10, 2'd0, 0, 0, 0, 1);
        chk(fill_level == 2 && cdc_valid, "R6 burst below half", 32'(cdc_valid), 1);
        step(0, 1, 2'b10, 2'd0, 0, 0, 0, 1);
        chk(st_empty && st_underrun && st_half_empty, "R8 drained flags",
            {29'b0, st_empty, st_underrun, st_half_empty}, 7);
        wr(32'h1, 0); wr(32'h2, 0); wr(32'h3, 0); wr(32'h4, 0);
        step(0, 1, 2'b10, 2'd0, 0, 0, 0, 1);   // take one pair -> 2 left
        step(0, 1, 2'b10, 2'd0, 0, 0, 0, 0);   // refused
        chk(!cdc_valid && fill_level == 2, "R6 refusal ends burst", 32'(cdc_valid), 0);
        wr(32'h5, 0); wr(32'h6, 0);            // 4 = half: half-empty cleared
        chk(!st_half_empty, "R7 half reached", 32'(st_half_empty), 0);
        cfg(1, 2'b00, 2'd0, 0);                // no slot
        chk(!cdc_valid, "R5 slot mask", 32'(cdc_valid), 0);
        cfg(1, 2'b01, 2'd0, 0);
        step(0, 1, 2'b01, 2'd0, 0, 0, 0, 1);
        step(0, 1, 2'b01, 2'd0, 0, 0, 0, 1);   // reaches zero
        chk(st_half_empty && st_empty, "R8 half after drain", 32'(st_half_empty), 1);

        for (int i = 0; i < 4000; i++) begin
            bit cw, dw, rd, ce, cc;
            bit [1:0] cs, cz;
            cw = ($urandom % 20) == 0;
            ce = ($urandom % 4) != 0;
            cs = 2'($urandom);
            cz = 2'($urandom);
            cc = 1'($urandom);
            dw = ($urandom % 10) < 6;
            rd = 1'($urandom);
            if (cw) step(1, ce, cs, cz, cc, dw, $urandom, rd);
            else    step(0, m_en, m_sl, m_sz, m_cp, dw, $urandom, rd);
        end
        done = 1;
        finish_run();
    end
endmodule